// File: doc/BRIEF.md
# Data Access Breakpoint and Alignment Checker

This block sits on the load/store address path of a processor core. Each access offers a 32-bit address and a flag that marks it as a store or a load. The block first relocates low addresses into the slot of the current process. A low address here is one whose top seven bits are zero, and it takes those bits from the process-slot input. The relocated address then goes to an alignment check. When checking is on, a misaligned access raises a one-cycle abort and loads fixed fault-status and fault-address registers.

The same relocated address is compared against two data breakpoints under a control word. Each breakpoint is armed separately for loads, stores or both. A mask mode turns the second breakpoint value into a "don't care" mask for the first. A hit gives a one-cycle pulse and writes the data-breakpoint entry code into the method-of-entry field. Breakpoint matching is turned off while the core is in debug halt.

The decisions are made combinationally on the request. They show up one cycle later as registered pulses and held register values.

Top module: `access_guard`

## Requirements
- R1: After synchronous reset, rsp_valid, rsp_addr, abort_pulse, fault_status, fault_addr, bp_hit_pulse and dbg_moe are all zero.
- R2: If cfg_pid is nonzero and request address bits 31:25 are all zero, those bits are replaced by cfg_pid. Otherwise the address passes unchanged. The result appears on rsp_addr one cycle after a valid request, with rsp_valid high. This relocated address is the one used by every later check.
- R3: With cfg_align_en high, a valid request whose relocated address has nonzero bits 1:0 gives abort_pulse high for exactly the next cycle. In that cycle fault_status equals 8'h01 and fault_addr equals the relocated address. With cfg_align_en low, or with an aligned address, no abort occurs.
- R4: fault_status and fault_addr keep their values on every cycle without an abort.
- R5: Each breakpoint has a 2-bit arm code. Breakpoint 0 uses cfg_bp_ctrl bits 1:0 and breakpoint 1 uses bits 3:2. The codes mean: 0 = disarmed, 1 = stores only, 2 = loads and stores, 3 = loads only.
- R6: When cfg_bp_ctrl bit 8 is 0, an armed breakpoint matches when the relocated address and its value agree in bits 31:2. Either breakpoint can cause a hit.
- R7: When cfg_bp_ctrl bit 8 is 1, a hit needs (addr & ~cfg_bp1) == (cfg_bp0 & ~cfg_bp1) under breakpoint 0's arm code. Breakpoint 1's arm code is ignored, and cfg_bp1 never matches on its own.
- R8: While cfg_dbg_halt is high, no breakpoint hit is reported and dbg_moe does not change. Alignment aborts are still raised.
- R9: A hit gives bp_hit_pulse high for exactly the cycle after the request and sets dbg_moe to 3'b010, which it then holds.
- R10: A cycle with req_valid low produces no abort or hit pulse in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request present |
| req_addr | input | 32 | Access address |
| req_store | input | 1 | 1 = store, 0 = load |
| cfg_pid | input | 7 | Process slot placed in bits 31:25 of low addresses |
| cfg_align_en | input | 1 | Alignment checking enable |
| cfg_bp0 | input | 32 | Breakpoint 0 address |
| cfg_bp1 | input | 32 | Breakpoint 1 address, or inverted mask in mask mode |
| cfg_bp_ctrl | input | 9 | Arm codes in bits 1:0 and 3:2, mask mode in bit 8 |
| cfg_dbg_halt | input | 1 | Debug halt mode active |
| rsp_valid | output | 1 | Registered copy of req_valid |
| rsp_addr | output | 32 | Relocated address of the last valid request |
| abort_pulse | output | 1 | One-cycle data abort |
| fault_status | output | 8 | Fault status register |
| fault_addr | output | 32 | Fault address register |
| bp_hit_pulse | output | 1 | One-cycle data breakpoint event |
| dbg_moe | output | 3 | Method-of-entry field |

## Verification
The hardest case to reach from the ports is mask mode. There a hit must depend only on breakpoint 0's arm code, and a second value that would match on its own must stay silent. The stimulus disarms breakpoint 1, then arms it for an address it would hit in normal mode. It then sets a mask that frees address bits the plain compare would check, and sends accesses that differ only inside and just outside the masked range. A second hard case is the interaction of relocation with the breakpoint compare. A nonzero process slot must make a low breakpoint address miss and a slot-qualified one hit. Debug halt is asserted while an access is both misaligned and matching, which separates the abort path from the breakpoint path.

// File: rtl/accguard_pkg.sv
package accguard_pkg;

    localparam int CTRL_W        = 9;
    localparam int EN0_LSB       = 0;
    localparam int EN1_LSB       = 2;
    localparam int MASK_BIT      = 8;
    localparam int MOE_W         = 3;
    localparam logic [MOE_W-1:0] MOE_DATA_BP = 3'b010;
    localparam int FAULT_ALIGN_CODE = 1;
    localparam int NUM_BP        = 2;

    typedef enum logic [1:0] {
        BP_OFF   = 2'd0,
        BP_STORE = 2'd1,
        BP_ANY   = 2'd2,
        BP_LOAD  = 2'd3
    } bp_en_e;

    typedef struct packed {
        logic   mask_mode;
        bp_en_e en1;
        bp_en_e en0;
    } bp_ctrl_t;

    function automatic logic kind_ok(bp_en_e en, logic is_store);
        case (en)
            BP_OFF:   return 1'b0;
            BP_STORE: return is_store;
            BP_LOAD:  return !is_store;
            default:  return 1'b1;
        endcase
    endfunction

endpackage

// File: rtl/ag_reloc.sv
module ag_reloc #(
    parameter int ADDR_W = 32,
    parameter int PID_W  = 7
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [PID_W-1:0]  pid_i,
    output logic [ADDR_W-1:0] addr_o
);
    localparam int LOW_W = ADDR_W - PID_W;

    logic slot_empty;
    assign slot_empty = (addr_i[ADDR_W-1:LOW_W] == '0);

    always_comb begin
        addr_o = addr_i;
        if (pid_i != '0 && slot_empty)
            addr_o[ADDR_W-1:LOW_W] = pid_i;
    end
endmodule

// File: rtl/ag_align.sv
module ag_align (
    input  logic [1:0] low_i,
    input  logic       en_i,
    output logic       fault_o
);
    assign fault_o = en_i && (low_i != 2'b00);
endmodule

// File: rtl/ag_bp_unit.sv
module ag_bp_unit
    import accguard_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              is_store_i,
    input  logic [ADDR_W-1:0] value_i,
    input  logic [ADDR_W-1:0] care_i,
    input  bp_en_e            en_i,
    output logic              hit_o
);
    logic addr_eq;
    assign addr_eq = (((addr_i ^ value_i) & care_i) == '0);
    assign hit_o   = kind_ok(en_i, is_store_i) && addr_eq;
endmodule

// File: rtl/access_guard.sv
module access_guard
    import accguard_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int PID_W  = 7,
    parameter int FSR_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_store,
    input  logic [PID_W-1:0]  cfg_pid,
    input  logic              cfg_align_en,
    input  logic [ADDR_W-1:0] cfg_bp0,
    input  logic [ADDR_W-1:0] cfg_bp1,
    input  logic [CTRL_W-1:0] cfg_bp_ctrl,
    input  logic              cfg_dbg_halt,
    output logic              rsp_valid,
    output logic [ADDR_W-1:0] rsp_addr,
    output logic              abort_pulse,
    output logic [FSR_W-1:0]  fault_status,
    output logic [ADDR_W-1:0] fault_addr,
    output logic              bp_hit_pulse,
    output logic [MOE_W-1:0]  dbg_moe
);
    localparam int LOW_W = ADDR_W - PID_W;
    localparam logic [ADDR_W-1:0] WORD_CARE = {{(ADDR_W-2){1'b1}}, 2'b00};

    // Control word decode
    bp_ctrl_t   ctl;
    logic [3:0] unused_ctrl_bits;
    assign ctl.en0       = bp_en_e'(cfg_bp_ctrl[EN0_LSB +: 2]);
    assign ctl.en1       = bp_en_e'(cfg_bp_ctrl[EN1_LSB +: 2]);
    assign ctl.mask_mode = cfg_bp_ctrl[MASK_BIT];
    assign unused_ctrl_bits = cfg_bp_ctrl[7:4];

    // Stage 1: process slot relocation
    logic [ADDR_W-1:0] eff_addr;
    ag_reloc #(.ADDR_W(ADDR_W), .PID_W(PID_W)) u_reloc (
        .addr_i (req_addr),
        .pid_i  (cfg_pid),
        .addr_o (eff_addr)
    );

    // Stage 2: alignment check
    logic misalign;
    ag_align u_align (
        .low_i   (eff_addr[1:0]),
        .en_i    (cfg_align_en),
        .fault_o (misalign)
    );

    // Stage 3: breakpoint compare
    logic [ADDR_W-1:0] bp_val  [NUM_BP];
    logic [ADDR_W-1:0] bp_care [NUM_BP];
    bp_en_e            bp_en   [NUM_BP];
    logic [NUM_BP-1:0] unit_hit;

    assign bp_val[0]  = cfg_bp0;
    assign bp_val[1]  = cfg_bp1;
    assign bp_care[0] = ctl.mask_mode ? ~cfg_bp1 : WORD_CARE;
    assign bp_care[1] = WORD_CARE;
    assign bp_en[0]   = ctl.en0;
    assign bp_en[1]   = ctl.mask_mode ? BP_OFF : ctl.en1;

    for (genvar g = 0; g < NUM_BP; g++) begin : g_bp
        ag_bp_unit #(.ADDR_W(ADDR_W)) u_unit (
            .addr_i     (eff_addr),
            .is_store_i (req_store),
            .value_i    (bp_val[g]),
            .care_i     (bp_care[g]),
            .en_i       (bp_en[g]),
            .hit_o      (unit_hit[g])
        );
    end

    logic take_abort;
    logic take_hit;
    assign take_abort = req_valid && misalign;
    assign take_hit   = req_valid && !cfg_dbg_halt && (unit_hit != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid    <= 1'b0;
            rsp_addr     <= '0;
            abort_pulse  <= 1'b0;
            fault_status <= '0;
            fault_addr   <= '0;
            bp_hit_pulse <= 1'b0;
            dbg_moe      <= '0;
        end else begin
            rsp_valid    <= req_valid;
            abort_pulse  <= take_abort;
            bp_hit_pulse <= take_hit;
            if (req_valid)
                rsp_addr <= eff_addr;
            if (take_abort) begin
                fault_status <= FSR_W'(FAULT_ALIGN_CODE);
                fault_addr   <= eff_addr;
            end
            if (take_hit)
                dbg_moe <= MOE_DATA_BP;
        end
    end

    // Assertions
    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> (!abort_pulse && !bp_hit_pulse));

    a_r8_halt_blocks_hit: assert property (@(posedge clk) disable iff (rst)
        (req_valid && cfg_dbg_halt) |=> !bp_hit_pulse);

    a_r3_abort_misaligned: assert property (@(posedge clk) disable iff (rst)
        abort_pulse |-> (fault_addr[1:0] != 2'b00));

    a_r4_fault_hold: assert property (@(posedge clk) disable iff (rst)
        !abort_pulse |-> ($stable(fault_addr) && $stable(fault_status)));

    a_r9_moe_code: assert property (@(posedge clk) disable iff (rst)
        bp_hit_pulse |-> (dbg_moe == MOE_DATA_BP));

    a_r2_slot_filled: assert property (@(posedge clk) disable iff (rst)
        (req_valid && cfg_pid != '0) |=> (rsp_addr[ADDR_W-1:LOW_W] != '0));

    a_r5_disarmed_silent: assert property (@(posedge clk) disable iff (rst)
        (req_valid && cfg_bp_ctrl[1:0] == 2'b00 &&
         (cfg_bp_ctrl[MASK_BIT] || cfg_bp_ctrl[3:2] == 2'b00)) |=> !bp_hit_pulse);
endmodule

// File: tb/access_guard_bench.sv
module access_guard_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        req_store = 1'b0;
    logic [6:0]  cfg_pid = '0;
    logic        cfg_align_en = 1'b0;
    logic [31:0] cfg_bp0 = '0;
    logic [31:0] cfg_bp1 = '0;
    logic [8:0]  cfg_bp_ctrl = '0;
    logic        cfg_dbg_halt = 1'b0;
    logic        rsp_valid;
    logic [31:0] rsp_addr;
    logic        abort_pulse;
    logic [7:0]  fault_status;
    logic [31:0] fault_addr;
    logic        bp_hit_pulse;
    logic [2:0]  dbg_moe;

    access_guard u_access_guard (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
        .req_store(req_store), .cfg_pid(cfg_pid), .cfg_align_en(cfg_align_en),
        .cfg_bp0(cfg_bp0), .cfg_bp1(cfg_bp1), .cfg_bp_ctrl(cfg_bp_ctrl),
        .cfg_dbg_halt(cfg_dbg_halt), .rsp_valid(rsp_valid), .rsp_addr(rsp_addr),
        .abort_pulse(abort_pulse), .fault_status(fault_status),
        .fault_addr(fault_addr), .bp_hit_pulse(bp_hit_pulse), .dbg_moe(dbg_moe)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    integer checks = 0;
    integer fails  = 0;
    bit     done   = 0;

    // Reference model state
    bit          m_valid;
    bit [31:0]   m_addr;
    bit          m_abort;
    bit [7:0]    m_fsr;
    bit [31:0]   m_far;
    bit          m_hit;
    bit [2:0]    m_moe;

    function automatic bit arm_allows(int code, bit st);
        if (code == 0) return 0;
        if (code == 1) return st;
        if (code == 3) return !st;
        return 1;
    endfunction

    task automatic model_update(bit v, bit [31:0] a, bit st);
        bit [31:0] ra;
        bit        h;
        bit [31:0] keep;
        ra = a;
        if (cfg_pid != 0 && a[31:25] == 7'd0) ra[31:25] = cfg_pid;
        m_valid = v;
        if (v) m_addr = ra;
        m_abort = v && cfg_align_en && (ra[1:0] != 2'b00);
        if (m_abort) begin
            m_fsr = 8'h01;
            m_far = ra;
        end
        h = 0;
        if (v && !cfg_dbg_halt) begin
            if (cfg_bp_ctrl[8]) begin
                keep = ~cfg_bp1;
                h = arm_allows(int'(cfg_bp_ctrl[1:0]), st) && ((ra & keep) == (cfg_bp0 & keep));
            end else begin
                if (arm_allows(int'(cfg_bp_ctrl[1:0]), st) && ra[31:2] == cfg_bp0[31:2]) h = 1;
                if (arm_allows(int'(cfg_bp_ctrl[3:2]), st) && ra[31:2] == cfg_bp1[31:2]) h = 1;
            end
        end
        m_hit = h;
        if (h) m_moe = 3'b010;
    endtask

    task automatic check(bit ok, string tag, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic compare(string tag);
        check(rsp_valid === m_valid && rsp_addr === m_addr, tag, "rsp",
              {31'd0, rsp_valid, rsp_addr}, {31'd0, m_valid, m_addr});
        check(abort_pulse === m_abort && fault_status === m_fsr && fault_addr === m_far,
              tag, "abort/fsr/far", {23'd0, abort_pulse, fault_status, fault_addr},
              {23'd0, m_abort, m_fsr, m_far});
        check(bp_hit_pulse === m_hit && dbg_moe === m_moe, tag, "hit/moe",
              {60'd0, bp_hit_pulse, dbg_moe}, {60'd0, m_hit, m_moe});
    endtask

    task automatic step(bit v, bit [31:0] a, bit st, string tag);
        req_valid = v;
        req_addr  = a;
        req_store = st;
        model_update(v, a, st);
        @(posedge clk);
        @(negedge clk);
        compare(tag);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        m_valid = 0; m_addr = 0; m_abort = 0; m_fsr = 0; m_far = 0; m_hit = 0; m_moe = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        compare("R1");

        // R2 relocation
        cfg_pid = 7'h55;
        step(1, 32'h0000_1234, 0, "R2");
        step(1, 32'h0200_0010, 0, "R2");
        cfg_pid = 7'h00;
        step(1, 32'h0000_1234, 1, "R2");

        // R3 alignment
        cfg_align_en = 1;
        step(1, 32'h0000_1001, 0, "R3");
        step(1, 32'h0000_2000, 1, "R3");
        step(1, 32'h0000_3003, 1, "R3");
        cfg_align_en = 0;
        step(1, 32'h0000_4002, 0, "R3");
        // R4 hold
        step(0, 32'h0000_0001, 0, "R4");
        step(1, 32'h0000_5000, 1, "R4");

        // R5 arm codes on breakpoint 0
        cfg_bp0 = 32'h0000_4000;
        cfg_bp_ctrl = 9'b0_0000_0000;
        step(1, 32'h0000_4000, 0, "R5");
        step(1, 32'h0000_4000, 1, "R5");
        cfg_bp_ctrl = 9'b0_0000_0001;
        step(1, 32'h0000_4000, 0, "R5");
        step(1, 32'h0000_4000, 1, "R5");
        cfg_bp_ctrl = 9'b0_0000_0011;
        step(1, 32'h0000_4000, 1, "R5");
        step(1, 32'h0000_4000, 0, "R5");
        cfg_bp_ctrl = 9'b0_0000_0010;
        step(1, 32'h0000_4000, 1, "R5");

        // R6 word compare and breakpoint 1
        step(1, 32'h0000_4003, 0, "R6");
        step(1, 32'h0000_4004, 0, "R6");
        cfg_bp1 = 32'h0000_9000;
        cfg_bp_ctrl = 9'b0_0000_1000;
        step(1, 32'h0000_9001, 0, "R6");
        step(1, 32'h0000_9001, 1, "R6");

        // R10 idle request must not pulse
        cfg_bp_ctrl = 9'b0_0000_1010;
        step(0, 32'h0000_4000, 0, "R10");

        // R2 relocation feeds the compare
        cfg_pid = 7'h03;
        step(1, 32'h0000_4000, 0, "R2");
        cfg_bp0 = 32'h0600_4000;
        step(1, 32'h0000_4000, 0, "R2");
        cfg_pid = 7'h00;

        // R7 mask mode
        cfg_bp0 = 32'h0000_5000;
        cfg_bp1 = 32'h0000_0F00;
        cfg_bp_ctrl = 9'b1_0000_0010;
        step(1, 32'h0000_5A00, 0, "R7");
        step(1, 32'h0000_5A04, 0, "R7");
        step(1, 32'h0000_0F00, 0, "R7");
        cfg_bp_ctrl = 9'b1_0000_1010;
        step(1, 32'h0000_0F00, 1, "R7");
        cfg_bp_ctrl = 9'b1_0000_0001;
        step(1, 32'h0000_5300, 0, "R7");
        step(1, 32'h0000_5300, 1, "R7");

        // R8 debug halt
        cfg_bp_ctrl = 9'b0_0000_0010;
        cfg_bp0 = 32'h0000_7000;
        cfg_align_en = 1;
        cfg_dbg_halt = 1;
        step(1, 32'h0000_7001, 0, "R8");
        cfg_dbg_halt = 0;
        // R9 hit sets entry code and holds it
        step(1, 32'h0000_7000, 1, "R9");
        step(1, 32'h0000_8000, 1, "R9");

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule